// File: doc/BRIEF.md
# I2C Bus Clock Generator with Standard and Fast Timing

This block derives the serial clock of an I2C master from the system clock. Software programs a 12-bit divider value, split over a 7-bit low field and a 5-bit high field, together with a timing mode bit. In standard timing one serial clock period lasts 2×CC+7 system clocks, divided almost evenly between the low and high phases. In fast timing it lasts 3×CC+9 system clocks, with the low phase about twice as long as the high phase.

Besides the clock level, the block gives two single-cycle strobes. One marks the point where the data line may change, at the start of the low phase. The other marks the point where the data line is sampled, at the start of the high phase. When the enable is low the clock stays released and the timer rests. The programmed settings are kept while the block is disabled. A new setting is picked up only at the start of a period, so a running period always completes with the timing it started with.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset the clock output is 1, both strobes are 0, and the divider value and mode bit are 0. Enabling without any configuration write then gives a 4-cycle low phase and a 3-cycle high phase.
- R2: One cycle after the enable is sampled low, the clock output is 1 and both strobes are 0. This holds for as long as the enable stays low.
- R3: With the mode bit at 0 (standard), each low phase lasts CC+4 system cycles and each high phase lasts CC+3 system cycles.
- R4: With the mode bit at 1 (fast), each low phase lasts 2×CC+5 system cycles and each high phase lasts CC+4 system cycles.
- R5: CC[6:0] is written from `cfg_lo_cc` when `cfg_lo_we` is 1, and the mode bit is written from `cfg_fast` at the same time. CC[11:7] is written from `cfg_hi_cc` when `cfg_hi_we` is 1. Each write leaves the other field unchanged.
- R6: Deasserting the enable does not clear the divider value or the mode bit. Enabling again without any write reproduces the earlier phase lengths.
- R7: The divider value and mode bit are captured at the start of each period, which is the cycle that begins a low phase. A write made during a period does not alter that period's length. It takes effect from the next period.
- R8: `sda_drive_stb` is 1 for exactly one cycle, the first cycle of each low phase, including the first low phase after enabling. `sda_sample_stb` is 1 for exactly one cycle, the first cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 holds the clock released |
| cfg_lo_we | input | 1 | Write strobe for the low divider field and mode bit |
| cfg_lo_cc | input | 7 | Divider bits [6:0] |
| cfg_fast | input | 1 | Mode bit: 0 standard, 1 fast |
| cfg_hi_we | input | 1 | Write strobe for the high divider field |
| cfg_hi_cc | input | 5 | Divider bits [11:7] |
| scl_o | output | 1 | Serial clock level (1 = released) |
| sda_drive_stb | output | 1 | One-cycle strobe at the start of each low phase |
| sda_sample_stb | output | 1 | One-cycle strobe at the start of each high phase |

## Verification
All outputs are registered. A configuration write or enable change sampled at one rising edge shows at the outputs after the next edge. When the block is enabled, the first drive strobe and low level appear one cycle after the enable is sampled. The bench drives inputs on falling edges and reads outputs on the following falling edge. A behavioural model applies each sampled input at the same rising edge as the design and is compared with the outputs on every cycle. Phase lengths are measured by counting falling edges between strobes.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    localparam int unsigned CC_LO_W = 7;
    localparam int unsigned CC_HI_W = 5;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
    parameter int unsigned LO_W = 7,
    parameter int unsigned HI_W = 5,
    localparam int unsigned CC_W = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic [LO_W-1:0] lo_val,
    input  logic            fast_val,
    input  logic            wr_hi,
    input  logic [HI_W-1:0] hi_val,
    output logic [CC_W-1:0] cc,
    output logic            fast
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        logic            fast;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_lo) begin
            cfg_d.lo   = lo_val;
            cfg_d.fast = fast_val;
        end
        if (wr_hi) begin
            cfg_d.hi = hi_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cc   = {cfg_q.hi, cfg_q.lo};
    assign fast = cfg_q.fast;

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> ($stable(cc) && $stable(fast)));

    // R5
    cfg_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (cc[LO_W-1:0] == $past(lo_val) && $stable(cc[CC_W-1:LO_W])));
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int unsigned CC_W  = 12,
    localparam int unsigned CNT_W = CC_W + 2
) (
    input  logic [CC_W-1:0]  cc,
    input  logic             fast,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len
);
    logic [CNT_W-1:0] cc_x1;
    logic [CNT_W-1:0] cc_x2;

    assign cc_x1 = {2'b00, cc};
    assign cc_x2 = {1'b0, cc, 1'b0};

    always_comb begin
        if (fast) begin
            low_len  = cc_x2 + CNT_W'(5);
            high_len = cc_x1 + CNT_W'(4);
        end else begin
            low_len  = cc_x1 + CNT_W'(4);
            high_len = cc_x1 + CNT_W'(3);
        end
    end
endmodule

// File: rtl/scl_timer.sv
module scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int unsigned CC_W  = 12,
    localparam int unsigned CNT_W = CC_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [CC_W-1:0] cfg_cc,
    input  logic            cfg_fast,
    output logic            scl,
    output logic            drv_stb,
    output logic            smp_stb
);
    typedef struct packed {
        logic             run;
        scl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [CC_W-1:0]  cc;
        logic             fast;
        logic             drv;
        logic             smp;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic             low_done;
    logic             high_done;

    scl_phase_len #(.CC_W(CC_W)) u_len (
        .cc       (st_q.cc),
        .fast     (st_q.fast),
        .low_len  (low_len),
        .high_len (high_len)
    );

    assign low_done  = (st_q.ph == PH_LOW)  && (st_q.cnt == low_len  - CNT_W'(1));
    assign high_done = (st_q.ph == PH_HIGH) && (st_q.cnt == high_len - CNT_W'(1));

    always_comb begin
        st_d     = st_q;
        st_d.drv = 1'b0;
        st_d.smp = 1'b0;
        if (!en) begin
            st_d.run = 1'b0;
            st_d.ph  = PH_LOW;
            st_d.cnt = '0;
        end else if (!st_q.run || high_done) begin
            st_d.run  = 1'b1;
            st_d.ph   = PH_LOW;
            st_d.cnt  = '0;
            st_d.cc   = cfg_cc;
            st_d.fast = cfg_fast;
            st_d.drv  = 1'b1;
        end else if (low_done) begin
            st_d.ph  = PH_HIGH;
            st_d.cnt = '0;
            st_d.smp = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scl     = !st_q.run || (st_q.ph == PH_HIGH);
    assign drv_stb = st_q.drv;
    assign smp_stb = st_q.smp;

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl && !drv_stb && !smp_stb));

    // R8
    drive_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_stb |-> $fell(scl));

    // R8
    sample_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> $rose(scl));

    // R3 R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < ((st_q.ph == PH_LOW) ? low_len : high_len)));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_stb |-> ($stable(st_q.cc) && $stable(st_q.fast)));
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
#(
    parameter int unsigned LO_W = CC_LO_W,
    parameter int unsigned HI_W = CC_HI_W,
    localparam int unsigned CC_W = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cfg_lo_we,
    input  logic [LO_W-1:0] cfg_lo_cc,
    input  logic            cfg_fast,
    input  logic            cfg_hi_we,
    input  logic [HI_W-1:0] cfg_hi_cc,
    output logic            scl_o,
    output logic            sda_drive_stb,
    output logic            sda_sample_stb
);
    logic [CC_W-1:0] cc;
    logic            fast;

    scl_cfg_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (cfg_lo_we),
        .lo_val   (cfg_lo_cc),
        .fast_val (cfg_fast),
        .wr_hi    (cfg_hi_we),
        .hi_val   (cfg_hi_cc),
        .cc       (cc),
        .fast     (fast)
    );

    scl_timer #(.CC_W(CC_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .cfg_cc   (cc),
        .cfg_fast (fast),
        .scl      (scl_o),
        .drv_stb  (sda_drive_stb),
        .smp_stb  (sda_sample_stb)
    );

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_drive_stb && sda_sample_stb));
endmodule

// File: tb/test_i2c_scl_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_lo_we = 1'b0;
    logic [6:0] cfg_lo_cc = '0;
    logic       cfg_fast = 1'b0;
    logic       cfg_hi_we = 1'b0;
    logic [4:0] cfg_hi_cc = '0;
    logic       scl_o;
    logic       sda_drive_stb;
    logic       sda_sample_stb;

    int errors = 0;
    int checks = 0;
    string cur_req = "R8";

    always #4 clk = ~clk;

    i2c_scl_gen i_i2c_scl_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .cfg_lo_we      (cfg_lo_we),
        .cfg_lo_cc      (cfg_lo_cc),
        .cfg_fast       (cfg_fast),
        .cfg_hi_we      (cfg_hi_we),
        .cfg_hi_cc      (cfg_hi_cc),
        .scl_o          (scl_o),
        .sda_drive_stb  (sda_drive_stb),
        .sda_sample_stb (sda_sample_stb)
    );

    // Behavioural reference: phase lengths counted down from the requirement formulas
    int m_lo = 0, m_hi = 0, m_fast = 0;
    int m_cc = 0, m_f = 0, m_left = 0;
    bit m_run = 0, m_scl = 1, m_drv = 0, m_smp = 0;

    function automatic int low_of(int cc, int f);
        return f ? 2 * cc + 5 : cc + 4;
    endfunction
    function automatic int high_of(int cc, int f);
        return f ? cc + 4 : cc + 3;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_fast = 0; m_cc = 0; m_f = 0; m_left = 0;
            m_run = 0; m_scl = 1; m_drv = 0; m_smp = 0;
        end else begin
            m_drv = 0;
            m_smp = 0;
            if (!enable) begin
                m_run = 0;
                m_scl = 1;
            end else if (!m_run || (m_scl && m_left == 1)) begin
                m_run  = 1;
                m_cc   = m_hi * 128 + m_lo;
                m_f    = m_fast;
                m_scl  = 0;
                m_left = low_of(m_cc, m_f);
                m_drv  = 1;
            end else if (!m_scl && m_left == 1) begin
                m_scl  = 1;
                m_left = high_of(m_cc, m_f);
                m_smp  = 1;
            end else begin
                m_left = m_left - 1;
            end
            if (cfg_lo_we) begin
                m_lo   = int'(cfg_lo_cc);
                m_fast = int'(cfg_fast);
            end
            if (cfg_hi_we) m_hi = int'(cfg_hi_cc);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (scl_o !== m_scl || sda_drive_stb !== m_drv || sda_sample_stb !== m_smp) begin
                errors++;
                $display("FAIL %s lockstep: scl/drv/smp actual %b%b%b expected %b%b%b at %0t",
                         cur_req, scl_o, sda_drive_stb, sda_sample_stb, m_scl, m_drv, m_smp, $time);
            end
        end
    end

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(int lo, int hi, bit f);
        @(negedge clk);
        cfg_lo_we = 1'b1; cfg_lo_cc = 7'(lo); cfg_fast = f;
        cfg_hi_we = 1'b1; cfg_hi_cc = 5'(hi);
        @(negedge clk);
        cfg_lo_we = 1'b0; cfg_hi_we = 1'b0;
    endtask

    task automatic wait_drv();
        while (sda_drive_stb !== 1'b1) @(negedge clk);
    endtask

    // Called at a falling edge where the drive strobe is 1; returns at the next one
    task automatic measure(output int lo, output int hi);
        lo = 0;
        while (scl_o === 1'b0) begin lo++; @(negedge clk); end
        hi = 0;
        while (scl_o === 1'b1 && sda_drive_stb !== 1'b1) begin hi++; @(negedge clk); end
    endtask

    task automatic run_and_measure(string req, int exp_lo, int exp_hi);
        int lo, hi;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        wait_drv();
        measure(lo, hi);
        check_val(req, "low phase", lo, exp_lo);
        check_val(req, "high phase", hi, exp_hi);
    endtask

    task automatic stop_and_check_idle(string req);
        int bad;
        @(negedge clk);
        enable = 1'b0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_o !== 1'b1 || sda_drive_stb !== 1'b0 || sda_sample_stb !== 1'b0) bad++;
        end
        check_val(req, "idle cycles with clock not released or strobe seen", bad, 0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lo, hi, n;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check_val("R1", "scl after reset", int'(scl_o), 1);
        check_val("R1", "drive strobe after reset", int'(sda_drive_stb), 0);
        check_val("R1", "sample strobe after reset", int'(sda_sample_stb), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_val("R1", "scl idle after reset release", int'(scl_o), 1);

        // R1 zero config -> standard CC=0
        run_and_measure("R1", 4, 3);

        // R2 disable holds line released
        stop_and_check_idle("R2");

        // R3 standard CC=5
        cfg(5, 0, 1'b0);
        run_and_measure("R3", 9, 8);
        stop_and_check_idle("R2");

        // R5 both fields: CC = 1*128+3 = 131
        cfg(3, 1, 1'b0);
        run_and_measure("R5", 135, 134);
        stop_and_check_idle("R2");

        // R4 fast CC=2 and CC=0
        cfg(2, 0, 1'b1);
        run_and_measure("R4", 9, 6);
        stop_and_check_idle("R2");
        cfg(0, 0, 1'b1);
        run_and_measure("R4", 5, 4);
        stop_and_check_idle("R2");

        // R6 settings survive disable
        cfg(2, 0, 1'b1);
        repeat (10) @(negedge clk);
        run_and_measure("R6", 9, 6);
        stop_and_check_idle("R2");
        repeat (10) @(negedge clk);
        run_and_measure("R6", 9, 6);
        stop_and_check_idle("R2");

        // R7 write inside a period waits for the boundary
        cfg(5, 0, 1'b0);
        run_and_measure("R3", 9, 8);
        cfg_lo_we = 1'b1; cfg_lo_cc = 7'd10; cfg_fast = 1'b0;
        @(negedge clk);
        cfg_lo_we = 1'b0;
        n = 1;
        while (sda_drive_stb !== 1'b1) begin @(negedge clk); n++; end
        check_val("R7", "period containing write", n, 17);
        measure(lo, hi);
        check_val("R7", "low phase after boundary", lo, 14);
        check_val("R7", "high phase after boundary", hi, 13);

        // R5 high field alone, R7 again: CC = 2*128+10 = 266
        cfg_hi_we = 1'b1; cfg_hi_cc = 5'd2;
        @(negedge clk);
        cfg_hi_we = 1'b0;
        n = 1;
        while (sda_drive_stb !== 1'b1) begin @(negedge clk); n++; end
        check_val("R7", "period containing high write", n, 27);
        measure(lo, hi);
        check_val("R5", "low phase with high field", lo, 270);
        check_val("R5", "high phase with high field", hi, 269);
        stop_and_check_idle("R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule